// File: doc/BRIEF.md
# One-Bit Accumulator Processor Core

This block is a very small processor whose data path is a single bit wide. It has a program store of 32 seven-bit instruction words, a five-bit program counter, a one-bit accumulator and a file of sixteen one-bit registers. Each clock cycle in which it runs, it takes the word at the program counter and reads the register that the word names. It forms one result bit and writes that bit either into the accumulator or into the named register. The program counter then moves on by one. There are no jumps. A program is a straight line that repeats every 32 cycles.

A host loads the program and gives the registers their starting values while the core is halted. It then raises the run input and watches the program counter, the accumulator and the register file on dedicated outputs. Host writes are single-cycle strobes with no handshake. Every write strobed while the core is halted is taken. A write strobed while the core runs is dropped, so the host never needs to wait on the core.

Instruction layout, most significant bit first: bit 6 is the store flag, bits 5:4 are the opcode, and bits 3:0 select a register.

Top module: `obc_core`

## Requirements
- R1: Opcode 2'b00 gives accumulator OR selected register, and opcode 2'b01 gives accumulator AND selected register. Both hold whether the store flag (bit 6) is 0 or 1.
- R2: Opcode 2'b10 gives the selected register's value when bit 6 is 0, and the accumulator's value when bit 6 is 1.
- R3: Opcode 2'b11 gives the inverted selected register when bit 6 is 0, and the inverted accumulator when bit 6 is 1.
- R4: When bit 6 is 0, the result is written into the accumulator at the clock edge, and no register changes.
- R5: When bit 6 is 1, the result is written into the register selected by bits 3:0, and the accumulator keeps its value.
- R6: While `run_en` is high, `pc_o` increases by one on every clock edge and wraps from 31 to 0.
- R7: A synchronous active-high `rst` clears `pc_o`, `acc_o` and all of `regs_o` to zero. It leaves program memory unchanged.
- R8: While `run_en` is low, `pc_o` and `acc_o` hold their values. A program write or register preset strobed in that cycle takes effect at the next edge.
- R9: Program writes and register presets strobed while `run_en` is high are dropped.
- R10: Program words that were never written read as 7'b0000000, which executes as accumulator OR register 0.
- R11: A result stored into a register can be read by the next instruction. A 31-word straight-line program built this way adds two 2-bit numbers in one 32-cycle pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Execute one instruction per cycle when high |
| pm_wr_en | input | 1 | Program write strobe (taken while halted) |
| pm_wr_addr | input | 5 | Program write address |
| pm_wr_data | input | 7 | Program write word |
| rf_set_en | input | 1 | Register preset strobe (taken while halted) |
| rf_set_idx | input | 4 | Register to preset |
| rf_set_val | input | 1 | Preset value |
| pc_o | output | 5 | Program counter |
| acc_o | output | 1 | Accumulator |
| regs_o | output | 16 | Register file, bit n is register n |

## Verification
The bench builds the core with its default values: 32 program words and 16 registers. With these values the counter wraps at 31, and the adder program uses 31 slots, leaving slot 31 as an unwritten zero word. The bench tries every combination of store flag, opcode, accumulator value and operand value. It runs a full wrap of the counter and all sixteen pairs of addends. It also strobes host writes into a running core to check that they are dropped.

// File: rtl/obc_pkg.sv
package obc_pkg;

  // Two-bit operation code carried in every instruction word
  typedef enum logic [1:0] {
    OPC_OR   = 2'b00,
    OPC_AND  = 2'b01,
    OPC_PASS = 2'b10,
    OPC_INV  = 2'b11
  } opc_e;

  // Result of one instruction; store selects accumulator-only forms
  function automatic logic eval_bit(input logic store, input opc_e opc,
                                    input logic acc, input logic opnd);
    logic src;
    src = store ? acc : opnd;
    case (opc)
      OPC_OR:   eval_bit = acc | opnd;
      OPC_AND:  eval_bit = acc & opnd;
      OPC_PASS: eval_bit = src;
      default:  eval_bit = ~src;
    endcase
  endfunction

endpackage

// File: rtl/obc_progmem.sv
module obc_progmem #(
  parameter int DEPTH  = 32,
  parameter int WORD_W = 7,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);

  // Not touched by reset; unwritten words start as zero
  logic [WORD_W-1:0] words [DEPTH] = '{default: '0};

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  assign rdata = words[raddr];

endmodule

// File: rtl/obc_regfile.sv
module obc_regfile #(
  parameter int NREG = 16,
  localparam int SW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            exec_we,
  input  logic [SW-1:0]   exec_sel,
  input  logic            exec_val,
  input  logic            host_we,
  input  logic [SW-1:0]   host_sel,
  input  logic            host_val,
  input  logic [SW-1:0]   rd_sel,
  output logic            rd_val,
  output logic [NREG-1:0] bits_o
);

  logic [NREG-1:0] bits_q;

  for (genvar g = 0; g < NREG; g++) begin : g_bit
    logic hit_exec, hit_host;
    assign hit_exec = exec_we && (exec_sel == SW'(g));
    assign hit_host = host_we && (host_sel == SW'(g));
    always_ff @(posedge clk) begin
      if (rst)           bits_q[g] <= 1'b0;
      else if (hit_exec) bits_q[g] <= exec_val;
      else if (hit_host) bits_q[g] <= host_val;
    end
  end

  assign rd_val = bits_q[rd_sel];
  assign bits_o = bits_q;

endmodule

// File: rtl/obc_alu.sv
module obc_alu
  import obc_pkg::*;
(
  input  logic       store,
  input  logic [1:0] opc,
  input  logic       acc,
  input  logic       opnd,
  output logic       res
);

  always_comb res = eval_bit(store, opc_e'(opc), acc, opnd);

endmodule

// File: rtl/obc_core.sv
module obc_core #(
  parameter int PROG_DEPTH = 32,
  parameter int NREG       = 16,
  localparam int PC_W      = $clog2(PROG_DEPTH),
  localparam int SEL_W     = $clog2(NREG),
  localparam int INSTR_W   = 3 + SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run_en,
  input  logic               pm_wr_en,
  input  logic [PC_W-1:0]    pm_wr_addr,
  input  logic [INSTR_W-1:0] pm_wr_data,
  input  logic               rf_set_en,
  input  logic [SEL_W-1:0]   rf_set_idx,
  input  logic               rf_set_val,
  output logic [PC_W-1:0]    pc_o,
  output logic               acc_o,
  output logic [NREG-1:0]    regs_o
);

  localparam logic [PC_W-1:0] PC_LAST = PC_W'(PROG_DEPTH - 1);

  logic [PC_W-1:0]    pc_q;
  logic               acc_q;
  logic [INSTR_W-1:0] instr;
  logic               i_store;
  logic [1:0]         i_opc;
  logic [SEL_W-1:0]   i_sel;
  logic               opnd, result;
  logic               host_ok;

  assign host_ok = !run_en;

  obc_progmem #(.DEPTH(PROG_DEPTH), .WORD_W(INSTR_W)) u_pm (
    .clk   (clk),
    .we    (pm_wr_en && host_ok),
    .waddr (pm_wr_addr),
    .wdata (pm_wr_data),
    .raddr (pc_q),
    .rdata (instr)
  );

  assign i_store = instr[INSTR_W-1];
  assign i_opc   = instr[INSTR_W-2 -: 2];
  assign i_sel   = instr[SEL_W-1:0];

  obc_regfile #(.NREG(NREG)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .exec_we  (run_en && i_store),
    .exec_sel (i_sel),
    .exec_val (result),
    .host_we  (rf_set_en && host_ok),
    .host_sel (rf_set_idx),
    .host_val (rf_set_val),
    .rd_sel   (i_sel),
    .rd_val   (opnd),
    .bits_o   (regs_o)
  );

  obc_alu u_alu (
    .store (i_store),
    .opc   (i_opc),
    .acc   (acc_q),
    .opnd  (opnd),
    .res   (result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      acc_q <= 1'b0;
    end else if (run_en) begin
      pc_q <= (pc_q == PC_LAST) ? '0 : pc_q + 1'b1;
      if (!i_store) acc_q <= result;
    end
  end

  assign pc_o  = pc_q;
  assign acc_o = acc_q;

endmodule

// File: rtl/obc_core_chk.sv
module obc_core_chk #(
  parameter int PC_W = 5,
  parameter int NREG = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            run_en,
  input logic            store,
  input logic [PC_W-1:0] pc,
  input logic            acc,
  input logic [NREG-1:0] regs
);

  // R6: counter steps by one per running cycle, wrapping at its width
  p_pc_step_r6: assert property (@(posedge clk) disable iff (rst)
    run_en |=> pc == PC_W'($past(pc) + 1'b1));

  // R8: halted core keeps counter and accumulator
  p_halt_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> $stable(pc) && $stable(acc));

  // R5: storing instruction leaves accumulator alone
  p_store_acc_r5: assert property (@(posedge clk) disable iff (rst)
    run_en && store |=> $stable(acc));

  // R4: non-storing instruction leaves registers alone
  p_load_regs_r4: assert property (@(posedge clk) disable iff (rst)
    run_en && !store |=> $stable(regs));

  // R7: reset clears architectural state
  p_reset_clear_r7: assert property (@(posedge clk)
    rst |=> pc == '0 && !acc && regs == '0);

endmodule

bind obc_core obc_core_chk #(.PC_W(PC_W), .NREG(NREG)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .run_en (run_en),
  .store  (i_store),
  .pc     (pc_o),
  .acc    (acc_o),
  .regs   (regs_o)
);

// File: tb/obc_core_bench.sv
module obc_core_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b0;
  logic        pm_wr_en = 1'b0;
  logic [4:0]  pm_wr_addr = '0;
  logic [6:0]  pm_wr_data = '0;
  logic        rf_set_en = 1'b0;
  logic [3:0]  rf_set_idx = '0;
  logic        rf_set_val = 1'b0;
  logic [4:0]  pc_o;
  logic        acc_o;
  logic [15:0] regs_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  obc_core u_obc_core (.*);

  function automatic logic [6:0] enc(input bit st, input int op, input int sel);
    return {st, 2'(op), 4'(sel)};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; cyc(2); rst = 1'b0;
    chk("R7 pc after reset", pc_o, 0);
    chk("R7 acc after reset", acc_o, 0);
    chk("R7 regs after reset", regs_o, 0);
  endtask

  task automatic wr_pm(input int a, input logic [6:0] d);
    pm_wr_en = 1'b1; pm_wr_addr = 5'(a); pm_wr_data = d;
    cyc(1); pm_wr_en = 1'b0;
  endtask

  task automatic clear_prog();
    for (int a = 0; a < 32; a++) wr_pm(a, 7'd0);
  endtask

  task automatic preset(input int i, input bit v);
    rf_set_en = 1'b1; rf_set_idx = 4'(i); rf_set_val = v;
    cyc(1); rf_set_en = 1'b0;
  endtask

  task automatic run(input int n);
    run_en = 1'b1; cyc(n); run_en = 1'b0;
  endtask

  // R10: untouched memory executes acc OR r0
  task automatic t_zero_word();
    do_reset();
    preset(0, 1'b1);
    run(1);
    chk("R10 zero word ORs r0 into acc", acc_o, 1);
    chk("R6 pc after one step", pc_o, 1);
  endtask

  // R1 R2 R3 R4 R5: every opcode, store flag and operand pair
  task automatic t_ops();
    for (int st = 0; st < 2; st++)
      for (int op = 0; op < 4; op++)
        for (int a = 0; a < 2; a++)
          for (int b = 0; b < 2; b++) begin
            bit src, res;
            string tag;
            do_reset();
            wr_pm(0, enc(0, 2, 15));
            wr_pm(1, enc(st[0], op, 2));
            preset(15, a[0]);
            preset(2, b[0]);
            run(2);
            src = st[0] ? a[0] : b[0];
            case (op)
              0: res = a[0] | b[0];
              1: res = a[0] & b[0];
              2: res = src;
              default: res = ~src;
            endcase
            tag = (op < 2) ? "R1" : (op == 2) ? "R2" : "R3";
            if (st == 1) begin
              chk($sformatf("%s R5 reg st=%0d op=%0d a=%0d b=%0d", tag, st, op, a, b), regs_o[2], res);
              chk($sformatf("R5 acc kept op=%0d a=%0d b=%0d", op, a, b), acc_o, a);
            end else begin
              chk($sformatf("%s R4 acc st=%0d op=%0d a=%0d b=%0d", tag, st, op, a, b), acc_o, res);
              chk($sformatf("R4 reg kept op=%0d a=%0d b=%0d", op, a, b), regs_o[2], b);
            end
            chk("R4 R5 other regs untouched", regs_o & 16'h7FFB, 0);
          end
  endtask

  // R6: full wrap of the counter
  task automatic t_wrap();
    do_reset();
    clear_prog();
    run(31);
    chk("R6 pc at 31", pc_o, 31);
    run(1);
    chk("R6 pc wraps to 0", pc_o, 0);
    run(1);
    chk("R6 pc after wrap", pc_o, 1);
  endtask

  // R8: halted state holds, host writes are taken
  task automatic t_hold();
    do_reset();
    clear_prog();
    wr_pm(0, enc(0, 3, 0));
    run(1);
    cyc(5);
    chk("R8 pc held while halted", pc_o, 1);
    chk("R8 acc held while halted", acc_o, 1);
    preset(9, 1'b1);
    chk("R8 preset taken while halted", regs_o[9], 1);
    chk("R8 acc unchanged by preset", acc_o, 1);
  endtask

  // R9: writes during a run are dropped
  task automatic t_ignore();
    do_reset();
    clear_prog();
    run_en = 1'b1;
    cyc(1);
    pm_wr_en = 1'b1; pm_wr_addr = 5'd20; pm_wr_data = enc(1, 3, 13);
    rf_set_en = 1'b1; rf_set_idx = 4'd12; rf_set_val = 1'b1;
    cyc(1);
    pm_wr_en = 1'b0; rf_set_en = 1'b0;
    cyc(30);
    run_en = 1'b0;
    chk("R9 preset during run dropped", regs_o[12], 0);
    chk("R9 program write during run dropped", regs_o[13], 0);
    chk("R9 pc after full pass", pc_o, 0);
  endtask

  // R7: reset keeps the program
  task automatic t_reset_keeps();
    do_reset();
    wr_pm(0, enc(0, 3, 0));
    run(3);
    do_reset();
    run(1);
    chk("R7 program survives reset", acc_o, 1);
  endtask

  // R11: two-bit adder program; x in r0(msb) r1, y in r2(msb) r3
  task automatic t_adder();
    logic [6:0] p [31];
    p = '{enc(0,3,3), enc(0,1,1), enc(1,2,7), enc(0,3,1), enc(0,1,3), enc(0,0,7), enc(1,2,4),
          enc(0,2,1), enc(0,1,3), enc(1,2,5),
          enc(0,3,2), enc(0,1,0), enc(1,2,7), enc(0,3,0), enc(0,1,2), enc(0,0,7), enc(1,2,9),
          enc(0,2,0), enc(0,1,2), enc(1,2,7), enc(0,2,5), enc(0,1,9), enc(0,0,7), enc(1,2,6),
          enc(0,3,5), enc(0,1,9), enc(1,2,7), enc(0,3,9), enc(0,1,5), enc(0,0,7), enc(1,2,8)};
    for (int x = 0; x < 4; x++)
      for (int y = 0; y < 4; y++) begin
        int s, got;
        do_reset();
        clear_prog();
        for (int k = 0; k < 31; k++) wr_pm(k, p[k]);
        preset(0, x[1]); preset(1, x[0]);
        preset(2, y[1]); preset(3, y[0]);
        run(32);
        s = x + y;
        got = {regs_o[6], regs_o[8], regs_o[4]};
        chk($sformatf("R11 sum %0d+%0d", x, y), got, s);
        chk("R11 pc back at 0", pc_o, 0);
      end
  endtask

  initial begin
    cyc(1);
    t_zero_word();
    t_ops();
    t_wrap();
    t_hold();
    t_ignore();
    t_reset_keeps();
    t_adder();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

endmodule